// File: doc/BRIEF.md
# Mask-Selected Bit-Field Extract and Insert Unit

This unit performs two byte-wide bit-field operations in which the field is chosen by a free-form 8-bit mask instead of an explicit offset and width. The shift distance is the index of the lowest set bit of the mask. A priority encoder finds that index.

Extract reads a source byte, keeps the bits selected by the mask and moves them down so that the lowest masked bit lands at bit 0. The result is meant for the low byte of a register. Insert moves a register byte up by the same distance, keeps the shifted bits that fall inside the mask, and merges them into a supplied destination byte. The merged byte is returned for write-back.

Requests use a valid/ready handshake with an opcode select. The result and a one-cycle done pulse are registered one cycle after a request is accepted. Address generation, memory cycles, decode and flag handling belong to the surrounding pipeline. The unit produces no flags of its own.

Top module: `mfx_unit`

## Requirements
- R1: With op = 0 (extract), the result is (src AND mask) shifted right by the index of the lowest set bit of mask. For example, src 0xA5 with mask 0xF0 gives 0x0A, with mask 0x3C gives 0x09, and with mask 0xFE gives 0x52.
- R2: With op = 1 (insert), the field is (src shifted left by the lowest-set-bit index of mask) AND mask. For example, src 0xA5 with mask 0x3C and dst 0x00 gives 0x14.
- R3: Insert returns the destination with every bit outside the mask kept and every bit inside the mask taken from the field. For example, dst 0xC3, src 0xA5 and mask 0x3C give 0xD7.
- R4: A zero mask makes extract return 0x00 and makes insert return dst unchanged.
- R5: Non-contiguous masks follow the same AND-and-shift rule, with no error indication. For example, extract of 0xA5 with mask 0x81 gives 0x81, and insert of 0xFF into dst 0xF5 with mask 0x0A gives 0xFF.
- R6: A request is accepted on a rising edge where req_valid and req_ready are both high. Exactly at the next edge res_done rises for one cycle with the new res_data. res_done is never high without an accepted request in the previous cycle.
- R7: Synchronous active-high reset clears res_data to 0x00 and res_done to 0, and holds req_ready low while reset is asserted. req_ready is high in every cycle after reset is released.
- R8: res_data holds its value in every cycle that follows a cycle without an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 1 | 0 = extract, 1 = insert |
| req_mask | input | 8 | Field-selecting mask |
| req_src | input | 8 | Extract: memory byte; insert: register byte |
| req_dst | input | 8 | Insert: current destination byte (ignored by extract) |
| res_done | output | 1 | One-cycle pulse marking a new result |
| res_data | output | 8 | Registered result byte |

## Verification
Faults in the lowest-set-bit encoder show up as shifted or truncated result bytes in the cycle after acceptance. Masks whose lowest set bit sits at each of positions 0 to 7 exercise every encoder output. A merge fault shows up as changed destination bits outside the mask, which the 0xC3 destination case exposes. A fault in the output register appears as a missing or extra done pulse, or as result drift in idle cycles that follow a request. A reset issued after a nonzero result shows whether the clear works.

// File: rtl/mfx_pkg.sv
package mfx_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned IDX_W  = $clog2(BYTE_W);

    typedef enum logic {
        MFX_EXTRACT = 1'b0,
        MFX_INSERT  = 1'b1
    } mfx_op_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              done;
        logic              ready;
    } mfx_state_t;
endpackage

// File: rtl/mfx_lsb_index.sv
module mfx_lsb_index #(
    parameter int unsigned W  = 8,
    localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  mask_i,
    output logic [IW-1:0] idx_o,
    output logic          none_o
);
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                idx_o = IW'(i);
            end
        end
        none_o = (mask_i == '0);
    end

    // R1: the chosen bit is set and no lower bit is set
    always_comb begin
        if (!none_o) begin
            a_r1_lsb_is_lowest: assert (mask_i[idx_o] &&
                ((mask_i & ((W'(1) << idx_o) - W'(1))) == '0));
        end
    end
endmodule

// File: rtl/mfx_extract.sv
module mfx_extract #(
    parameter int unsigned W  = 8,
    localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  src_i,
    input  logic [W-1:0]  mask_i,
    input  logic [IW-1:0] shamt_i,
    input  logic          none_i,
    output logic [W-1:0]  field_o
);
    logic [W-1:0] picked;

    always_comb begin
        picked  = src_i & mask_i;
        field_o = none_i ? '0 : (picked >> shamt_i);
    end

    // R4: zero mask yields zero
    always_comb begin
        if (mask_i == '0) begin
            a_r4_extract_zero: assert (field_o == '0);
        end
    end
endmodule

// File: rtl/mfx_insert.sv
module mfx_insert #(
    parameter int unsigned W  = 8,
    localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  src_i,
    input  logic [W-1:0]  dst_i,
    input  logic [W-1:0]  mask_i,
    input  logic [IW-1:0] shamt_i,
    input  logic          none_i,
    output logic [W-1:0]  merged_o
);
    logic [W-1:0] placed;

    always_comb begin
        placed   = (src_i << shamt_i) & mask_i;
        merged_o = none_i ? dst_i : ((dst_i & ~mask_i) | placed);
    end

    // R3: bits outside the mask never change
    always_comb begin
        a_r3_outside_kept: assert (((merged_o ^ dst_i) & ~mask_i) == '0);
    end
endmodule

// File: rtl/mfx_unit.sv
module mfx_unit
    import mfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic [BYTE_W-1:0] req_mask,
    input  logic [BYTE_W-1:0] req_src,
    input  logic [BYTE_W-1:0] req_dst,
    output logic              res_done,
    output logic [BYTE_W-1:0] res_data
);
    logic [IDX_W-1:0]  shamt;
    logic              mask_none;
    logic [BYTE_W-1:0] ext_val;
    logic [BYTE_W-1:0] ins_val;
    logic              accept;
    mfx_state_t        st_d, st_q;

    mfx_lsb_index #(.W(BYTE_W)) u_idx (
        .mask_i (req_mask),
        .idx_o  (shamt),
        .none_o (mask_none)
    );

    mfx_extract #(.W(BYTE_W)) u_ext (
        .src_i   (req_src),
        .mask_i  (req_mask),
        .shamt_i (shamt),
        .none_i  (mask_none),
        .field_o (ext_val)
    );

    mfx_insert #(.W(BYTE_W)) u_ins (
        .src_i    (req_src),
        .dst_i    (req_dst),
        .mask_i   (req_mask),
        .shamt_i  (shamt),
        .none_i   (mask_none),
        .merged_o (ins_val)
    );

    assign accept = req_valid && st_q.ready;

    always_comb begin
        st_d       = st_q;
        st_d.ready = 1'b1;
        st_d.done  = accept;
        if (accept) begin
            st_d.data = (mfx_op_e'(req_op) == MFX_INSERT) ? ins_val : ext_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = st_q.ready;
    assign res_done  = st_q.done;
    assign res_data  = st_q.data;

    a_r6_done_needs_accept: assert property (@(posedge clk) disable iff (rst)
        res_done |-> $past(req_valid && req_ready));
    a_r6_accept_gives_done: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> res_done);
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> $stable(res_data));
    a_r7_reset_clears: assert property (@(posedge clk)
        rst |=> (!res_done && res_data == '0 && !req_ready));
endmodule

// File: tb/mfx_unit_tb_top.sv
module mfx_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_op = 1'b0;
    logic [7:0] req_mask = '0;
    logic [7:0] req_src = '0;
    logic [7:0] req_dst = '0;
    logic       req_ready;
    logic       res_done;
    logic [7:0] res_data;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    mfx_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_mask  (req_mask),
        .req_src   (req_src),
        .req_dst   (req_dst),
        .res_done  (res_done),
        .res_data  (res_data)
    );

    // {op, mask, src, dst, expected}
    localparam int NV = 26;
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 8'h01, 8'hA5, 8'h00, 8'h01},
        {1'b0, 8'h02, 8'hA5, 8'h00, 8'h00},
        {1'b0, 8'h07, 8'hA5, 8'h00, 8'h05},
        {1'b0, 8'h10, 8'hA5, 8'h00, 8'h00},
        {1'b0, 8'h20, 8'hA5, 8'h00, 8'h01},
        {1'b0, 8'hF0, 8'hA5, 8'h00, 8'h0A},
        {1'b0, 8'h80, 8'hA5, 8'h00, 8'h01},
        {1'b0, 8'h40, 8'hA5, 8'h00, 8'h00},
        {1'b0, 8'hE0, 8'hA5, 8'h00, 8'h05},
        {1'b0, 8'h3C, 8'hA5, 8'h00, 8'h09},
        {1'b0, 8'hFE, 8'hA5, 8'h00, 8'h52},
        {1'b0, 8'h08, 8'hA5, 8'hFF, 8'h00},
        {1'b1, 8'h01, 8'hA5, 8'h00, 8'h01},
        {1'b1, 8'h02, 8'hA5, 8'h00, 8'h02},
        {1'b1, 8'h07, 8'hA5, 8'h00, 8'h05},
        {1'b1, 8'h10, 8'hA5, 8'h00, 8'h10},
        {1'b1, 8'h20, 8'hA5, 8'h00, 8'h20},
        {1'b1, 8'hF0, 8'hA5, 8'h00, 8'h50},
        {1'b1, 8'h80, 8'hA5, 8'h00, 8'h80},
        {1'b1, 8'h40, 8'hA5, 8'h00, 8'h40},
        {1'b1, 8'hE0, 8'hA5, 8'h00, 8'hA0},
        {1'b1, 8'h3C, 8'hA5, 8'h00, 8'h14},
        {1'b1, 8'hFE, 8'hA5, 8'h00, 8'h4A},
        {1'b1, 8'h38, 8'hA5, 8'h00, 8'h28},
        {1'b1, 8'h3C, 8'hA5, 8'hC3, 8'hD7},
        {1'b1, 8'h08, 8'h01, 8'hF7, 8'hFF}
    };

    task automatic check(input bit ok, input string req, input logic [8:0] act,
                         input logic [8:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at negedge, accept on next posedge, sample at following negedge
    task automatic run_req(input logic op, input logic [7:0] m, input logic [7:0] s,
                           input logic [7:0] d, input logic [7:0] exp, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_mask = m; req_src = s; req_dst = d;
        @(negedge clk);
        req_valid = 1'b0;
        check(res_done === 1'b1 && res_data === exp, req,
              {res_done, res_data}, {1'b1, exp});
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        // R7: state during reset
        check(res_done === 1'b0 && res_data === 8'h00 && req_ready === 1'b0, "R7 reset",
              {res_done, res_data}, 9'h000);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready === 1'b1, "R7 ready after reset", {8'h0, req_ready}, 9'h001);

        for (int i = 0; i < NV; i++) begin
            run_req(VEC[i][32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0],
                    VEC[i][32] ? "R2/R3 insert" : "R1 extract");
        end

        // R4: zero mask
        run_req(1'b0, 8'h00, 8'hA5, 8'h00, 8'h00, "R4 extract zero mask");
        run_req(1'b1, 8'h00, 8'hA5, 8'h5A, 8'h5A, "R4 insert zero mask");
        run_req(1'b1, 8'h00, 8'hA5, 8'h00, 8'h00, "R4 insert zero mask zero dst");

        // R5: non-contiguous masks
        run_req(1'b0, 8'h81, 8'hA5, 8'h00, 8'h81, "R5 extract split mask");
        run_req(1'b1, 8'h81, 8'h03, 8'h00, 8'h01, "R5 insert split mask");
        run_req(1'b1, 8'h0A, 8'hFF, 8'hF5, 8'hFF, "R5 insert split merge");
        run_req(1'b0, 8'h5A, 8'hFF, 8'h00, 8'h2D, "R5 extract alternating");

        // R6, R8: pulse is one cycle, result held while idle with changing inputs
        held = res_data;
        req_op = 1'b1; req_mask = 8'hFF; req_src = 8'h11; req_dst = 8'h22;
        @(negedge clk);
        check(res_done === 1'b0, "R6 single pulse", {8'h0, res_done}, 9'h000);
        check(res_data === held, "R8 idle hold", {1'b0, res_data}, {1'b0, held});
        @(negedge clk);
        check(res_data === held && res_done === 1'b0, "R8 idle hold 2",
              {res_done, res_data}, {1'b0, held});

        // R6: back-to-back requests each produce a pulse
        @(negedge clk);
        req_valid = 1'b1; req_op = 1'b0; req_mask = 8'h0F; req_src = 8'h3C;
        @(negedge clk);
        check(res_done === 1'b1 && res_data === 8'h0C, "R6 back-to-back first",
              {res_done, res_data}, 9'h10C);
        req_op = 1'b1; req_mask = 8'hF0; req_src = 8'h07; req_dst = 8'h0F;
        @(negedge clk);
        req_valid = 1'b0;
        check(res_done === 1'b1 && res_data === 8'h7F, "R6 back-to-back second",
              {res_done, res_data}, 9'h17F);

        // R7: reset mid-run clears a nonzero result
        run_req(1'b0, 8'hFF, 8'hC9, 8'h00, 8'hC9, "R1 full mask");
        rst = 1'b1;
        @(negedge clk);
        check(res_data === 8'h00 && res_done === 1'b0 && req_ready === 1'b0,
              "R7 reset clears", {res_done, res_data}, 9'h000);
        rst = 1'b0;
        @(negedge clk);
        run_req(1'b1, 8'hC0, 8'h02, 8'h3F, 8'hBF, "R3 top field merge");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule